// File: doc/BRIEF.md
# Sensor Unlock UART Transmitter

This block drives the serial input of a sensor that refuses configuration traffic until it has received a fixed unlock pattern. When a start request arrives, it transmits the unlock byte (0xD4 by default) ten times. After each copy the line is held idle for a timed gap of 1 ms by default. It then sends a block of command bytes taken from a wide parallel word and signals completion with a one-cycle pulse.

Each character uses the same fixed format: 8 data bits, even parity and two stop bits. The bit period and the gap length come from a clock-frequency parameter at elaboration. A single clock drives all timing; plain down-counters replace any divided clock. The command word is captured when the request is accepted, so the requester may change it while the transfer runs.

Top module: `sensor_unlock_tx`

## Requirements
- R1: After reset, `tx` is 1 (idle), `busy` is 0 and `done` is 0.
- R2: The first UNLOCK_REPS characters (default 10) of a sequence carry the value UNLOCK_BYTE (default 0xD4).
- R3: After each unlock character, the line stays at 1 for exactly GAP_CYC = CLK_FREQ*GAP_US/1000000 clock cycles (integer division) before the next start bit.
- R4: After the unlock characters, CMD_BYTES characters (default 8) carry the command word captured at start, least significant byte (bits 7:0) first, then bits 15:8, and so on.
- R5: Consecutive command characters are separated by exactly 2 clock cycles of idle line.
- R6: The parity bit makes the number of ones across the 8 data bits and the parity bit even.
- R7: Each character is a start bit of 0, then the data bits least significant first, then the parity bit, then two stop bits of 1. Every bit lasts BIT_CYC = round(CLK_FREQ/BAUD) cycles.
- R8: `busy` rises in the cycle after a start request is accepted and stays high until the final stop bit has ended. `done` is then high for exactly one cycle, and `busy` is already 0 in that cycle.
- R9: A start request while `busy` is high is ignored: the sequence runs on unchanged, and no extra characters follow it.
- R10: Changes of `cmd_word` while `busy` is high do not affect the transmitted command characters.
- R11: A start request in the same cycle as the `done` pulse is accepted and begins a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send the unlock preamble and command block |
| cmd_word | input | CMD_BYTES*8 | Command bytes, low byte sent first |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The bench waits until it sees `done` high, drives `start` high for that one cycle, and then expects `busy` to rise again. It also expects the full unlock-plus-command sequence to be decoded again from the line with the correct gaps. The opposite case also matters: a start request that lands while `busy` is high and the sequence has not finished. Such a request is judged by the decoded character count and by the line staying idle once the single sequence has completed.

// File: rtl/sutx_pkg.sv
package sutx_pkg;

    localparam int FRAME_BITS = 12;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT,
        SQ_GAP
    } seq_state_t;

    // Shifted out from bit 0 upward
    typedef struct packed {
        logic [1:0] stop;
        logic       parity;
        logic [7:0] data;
        logic       start;
    } frame_t;

    function automatic frame_t make_frame(input logic [7:0] d);
        frame_t f;
        f.stop   = 2'b11;
        f.parity = ^d;
        f.data   = d;
        f.start  = 1'b0;
        return f;
    endfunction

    function automatic int bit_cycles(input longint clk_hz, input longint baud);
        return int'((clk_hz + baud / 2) / baud);
    endfunction

    function automatic int gap_cycles(input longint clk_hz, input longint usec);
        return int'((clk_hz * usec) / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/sutx_shifter.sv
module sutx_shifter
    import sutx_pkg::*;
#(
    parameter int BIT_CYC = 434
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       tx_o,
    output logic       active_o,
    output logic       frame_done_o
);

    localparam int CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;

    logic [FRAME_BITS-1:0] sh_q;
    logic                  active_q;
    logic [CW-1:0]         cyc_q;
    logic [3:0]            left_q;
    logic                  done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '1;
            active_q <= 1'b0;
            cyc_q    <= '0;
            left_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (load_i) begin
                    sh_q     <= make_frame(byte_i);
                    active_q <= 1'b1;
                    cyc_q    <= CW'(BIT_CYC - 1);
                    left_q   <= 4'(FRAME_BITS - 1);
                end
            end else if (cyc_q == '0) begin
                if (left_q == '0) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
                    left_q <= left_q - 4'd1;
                    cyc_q  <= CW'(BIT_CYC - 1);
                end
            end else begin
                cyc_q <= cyc_q - CW'(1);
            end
        end
    end

    assign tx_o         = active_q ? sh_q[0] : 1'b1;
    assign active_o     = active_q;
    assign frame_done_o = done_q;

    // R7
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !active_q) |=> (tx_o == 1'b0));

    // R7
    last_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && cyc_q == '0 && left_q == '0) |-> (tx_o == 1'b1));

    // R7
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !active_q);

endmodule

// File: rtl/sutx_gap_timer.sv
module sutx_gap_timer #(
    parameter int GAP_LOAD = 49997
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic run_o
);

    localparam int GW = (GAP_LOAD > 0) ? $clog2(GAP_LOAD + 1) : 1;

    logic [GW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= GW'(GAP_LOAD);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - GW'(1);
            end
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/sutx_sequencer.sv
module sutx_sequencer
    import sutx_pkg::*;
#(
    parameter int         REPS        = 10,
    parameter int         CMD_BYTES   = 8,
    parameter logic [7:0] UNLOCK_BYTE = 8'hD4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [CMD_BYTES*8-1:0] payload_i,
    input  logic                   frame_done_i,
    input  logic                   frame_active_i,
    input  logic                   gap_run_i,
    output logic                   load_o,
    output logic [7:0]             byte_o,
    output logic                   gap_load_o,
    output logic                   busy_o,
    output logic                   done_o
);

    localparam int PW   = CMD_BYTES * 8;
    localparam int NTOT = REPS + CMD_BYTES;
    localparam int IW   = $clog2(NTOT + 1);
    localparam int LAST = NTOT - 1;

    seq_state_t    st_q;
    logic [IW-1:0] idx_q;
    logic [PW-1:0] pay_q;
    logic          done_q;
    logic          in_unlock;

    assign in_unlock  = (idx_q < IW'(REPS));
    assign load_o     = (st_q == SQ_LOAD) || (st_q == SQ_GAP && !gap_run_i);
    assign byte_o     = in_unlock ? UNLOCK_BYTE : pay_q[7:0];
    assign gap_load_o = (st_q == SQ_WAIT) && frame_done_i && in_unlock;
    assign busy_o     = (st_q != SQ_IDLE);
    assign done_o     = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            idx_q  <= '0;
            pay_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        pay_q <= payload_i;
                        idx_q <= '0;
                        st_q  <= SQ_LOAD;
                    end
                end
                SQ_LOAD: st_q <= SQ_WAIT;
                SQ_GAP: begin
                    if (!gap_run_i) st_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (frame_done_i) begin
                        if (idx_q == IW'(LAST)) begin
                            st_q   <= SQ_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                            st_q  <= in_unlock ? SQ_GAP : SQ_LOAD;
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
            if (load_o && !in_unlock) begin
                pay_q <= pay_q >> 8;
            end
        end
    end

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (idx_q >= $past(idx_q)));

    // R3
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_GAP) |-> !frame_active_i);

endmodule

// File: rtl/sensor_unlock_tx.sv
module sensor_unlock_tx
    import sutx_pkg::*;
#(
    parameter int         CLK_FREQ    = 50_000_000,
    parameter int         BAUD        = 115_200,
    parameter int         GAP_US      = 1000,
    parameter logic [7:0] UNLOCK_BYTE = 8'hD4,
    parameter int         UNLOCK_REPS = 10,
    parameter int         CMD_BYTES   = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CMD_BYTES*8-1:0] cmd_word,
    output logic                   tx,
    output logic                   busy,
    output logic                   done
);

    localparam int BIT_CYC  = bit_cycles(CLK_FREQ, BAUD);
    localparam int GAP_CYC  = gap_cycles(CLK_FREQ, GAP_US);
    // Three cycles of the idle gap are spent in the handoff registers
    localparam int GAP_LOAD = GAP_CYC - 3;

    logic       load;
    logic [7:0] tx_byte;
    logic       frame_active;
    logic       frame_done;
    logic       gap_load;
    logic       gap_run;

    sutx_sequencer #(
        .REPS        (UNLOCK_REPS),
        .CMD_BYTES   (CMD_BYTES),
        .UNLOCK_BYTE (UNLOCK_BYTE)
    ) u_seq (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .payload_i      (cmd_word),
        .frame_done_i   (frame_done),
        .frame_active_i (frame_active),
        .gap_run_i      (gap_run),
        .load_o         (load),
        .byte_o         (tx_byte),
        .gap_load_o     (gap_load),
        .busy_o         (busy),
        .done_o         (done)
    );

    sutx_gap_timer #(
        .GAP_LOAD (GAP_LOAD)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load_i (gap_load),
        .run_o  (gap_run)
    );

    sutx_shifter #(
        .BIT_CYC (BIT_CYC)
    ) u_shift (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .byte_i       (tx_byte),
        .tx_o         (tx),
        .active_o     (frame_active),
        .frame_done_o (frame_done)
    );

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

endmodule

// File: tb/sensor_unlock_tx_test.sv
module sensor_unlock_tx_test;

    localparam int TB_CLK  = 1_152_000;
    localparam int TB_BAUD = 115_200;
    localparam int TB_GAP  = 100;
    localparam int REPS    = 10;
    localparam int NCMD    = 8;
    localparam int NTOT    = REPS + NCMD;
    localparam int EXP_BIT = (TB_CLK + TB_BAUD / 2) / TB_BAUD;
    localparam int EXP_GAP = int'((64'(TB_CLK) * TB_GAP) / 1_000_000);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] cmd_word = '0;
    logic        tx, busy, done;

    always #5 clk = ~clk;

    sensor_unlock_tx #(
        .CLK_FREQ    (TB_CLK),
        .BAUD        (TB_BAUD),
        .GAP_US      (TB_GAP),
        .UNLOCK_BYTE (8'hD4),
        .UNLOCK_REPS (REPS),
        .CMD_BYTES   (NCMD)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_word (cmd_word),
        .tx       (tx),
        .busy     (busy),
        .done     (done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] f_data [0:63];
    logic       f_par  [0:63];
    logic       f_ok   [0:63];
    int         f_gap  [0:63];
    int         nf = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Line decoder: samples each bit at its centre on falling clock edges
    initial begin
        int run;
        logic [11:0] bits;
        run = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                run = 0;
            end else if (tx) begin
                run++;
            end else begin
                if (nf < 64) f_gap[nf] = run;
                repeat (EXP_BIT / 2) @(negedge clk);
                bits[0] = tx;
                for (int b = 1; b < 12; b++) begin
                    repeat (EXP_BIT) @(negedge clk);
                    bits[b] = tx;
                end
                if (nf < 64) begin
                    f_data[nf] = bits[8:1];
                    f_par[nf]  = bits[9];
                    f_ok[nf]   = (bits[0] == 1'b0) && (bits[11:10] == 2'b11);
                end
                nf++;
                repeat (EXP_BIT - EXP_BIT / 2 - 1) @(negedge clk);
                run = 0;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", 64'(busy), 64'd1);
    endtask

    // Returns at the falling edge where done is first seen high
    task automatic wait_done();
        int lim;
        int busy_low;
        lim = 0;
        busy_low = 0;
        while (done !== 1'b1 && lim < 20000) begin
            if (busy !== 1'b1) busy_low++;
            @(negedge clk);
            lim++;
        end
        chk("R8 busy held until end", 64'(busy_low), 64'd0);
        chk("R8 done seen", 64'(done), 64'd1);
        chk("R8 busy low during done", 64'(busy), 64'd0);
    endtask

    task automatic check_frames(input logic [63:0] pay);
        int ones;
        chk("R9 character count", 64'(nf), 64'(NTOT));
        for (int i = 0; i < NTOT && i < nf; i++) begin
            if (i < REPS) chk("R2 unlock byte", 64'(f_data[i]), 64'hD4);
            else          chk("R4 command byte order", 64'(f_data[i]), 64'(pay[8*(i-REPS) +: 8]));
            ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(f_data[i][b]);
            chk("R6 even parity", 64'(f_par[i]), 64'(ones % 2));
            chk("R7 start and stop bits", 64'(f_ok[i]), 64'd1);
            if (i >= 1 && i <= REPS) chk("R3 unlock gap", 64'(f_gap[i]), 64'(EXP_GAP));
            if (i > REPS)            chk("R5 command spacing", 64'(f_gap[i]), 64'd2);
        end
    endtask

    task automatic t_reset();
        chk("R1 idle line", 64'(tx), 64'd1);
        chk("R1 busy low", 64'(busy), 64'd0);
        chk("R1 done low", 64'(done), 64'd0);
    endtask

    task automatic t_sequence(input logic [63:0] pay);
        nf = 0;
        cmd_word = pay;
        pulse_start();
        wait_done();
        @(negedge clk);
        chk("R8 done single cycle", 64'(done), 64'd0);
        check_frames(pay);
    endtask

    task automatic t_ignore();
        logic [63:0] pay;
        pay = 64'h5A3C_0F99_E1_7E_80_01;
        nf = 0;
        cmd_word = pay;
        pulse_start();
        cmd_word = ~pay;
        repeat (400) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (1600) @(negedge clk);
        cmd_word = 64'h1111_2222_3333_4444;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_frames(pay);   // R10: captured word, R9: nothing extra
        repeat (400) @(negedge clk);
        chk("R9 no extra characters", 64'(nf), 64'(NTOT));
        chk("R9 busy stays low", 64'(busy), 64'd0);
        chk("R9 line idle", 64'(tx), 64'd1);
    endtask

    task automatic t_back_to_back();
        logic [63:0] p1, p2;
        p1 = 64'hFEDC_BA98_7654_3210;
        p2 = 64'h00FF_55AA_C3_3C_01_80;
        nf = 0;
        cmd_word = p1;
        pulse_start();
        wait_done();
        start = 1'b1;        // R11: request in the done cycle
        cmd_word = p2;
        check_frames(p1);
        nf = 0;
        @(negedge clk);
        start = 1'b0;
        chk("R11 restart accepted", 64'(busy), 64'd1);
        wait_done();
        check_frames(p2);    // R11 full new sequence
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sequence(64'h0123_4567_89AB_CDEF);
        t_sequence(64'hFFFF_FFFF_FFFF_FFFF);
        t_sequence(64'h8000_0000_0000_0001);
        t_ignore();
        t_back_to_back();
        repeat (20) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule